// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block is the interlock for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that has no operand forwarding. It compares the source register numbers of the instruction sitting in decode with the destination numbers and write flags of the three older instructions in execute, memory and write-back. It also watches for a branch in decode and for a branch in execute together with its resolved outcome. From these inputs it decides, in the same cycle, whether the fetch address and the fetch/decode register must hold, whether the fetch/decode register must be cleared, whether a bubble goes into the decode/execute register, and whether fetch must jump to the branch target.

Every hazard is resolved by stalling alone. A consumer waits in decode until its producer has fully left write-back, so a load followed at once by a dependent instruction costs three bubbles. Fetch stays frozen while a branch moves from decode into execute. The instruction fetched behind the branch is discarded and later fetched again from the right address. A bubble is an all-zero control word. Its source numbers are zero and its write flags are low, so it never creates a dependency and never changes architectural state.

The block is purely combinational. Clock and reset feed only the embedded property checks.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: A source register number of zero never causes a stall. A producer whose write flag is low never causes a stall.
- R2: If either decode source (slot i at bits [i*REG_W +: REG_W] of `dec_src`) is non-zero and equals the destination of a producer whose write flag is set, there is a data stall. Producer index 0 is execute, 1 is memory and 2 is write-back. With no execute branch, a data stall gives `pc_hold`=1, `ifid_hold`=1, `idex_bubble`=1, `ifid_clear`=0 and `pc_redirect`=0.
- R3: Take a load in execute whose destination is read by the instruction in decode, with stages advancing each cycle. The controller emits exactly three bubble cycles, and decode is released in the fourth cycle, once the load has left write-back.
- R4: A branch in decode with no data stall and no execute branch gives `pc_hold`=1, `ifid_clear`=1, `ifid_hold`=0, `idex_bubble`=0 and `pc_redirect`=0.
- R5: A branch in execute that is taken gives `pc_redirect`=1, `pc_hold`=0 and `ifid_clear`=1.
- R6: A branch in execute that is not taken gives `pc_redirect`=0, `pc_hold`=1 and `ifid_clear`=1, so the held address is fetched again.
- R7: A data stall together with a branch in decode gives `pc_hold`=1, `ifid_hold`=1, `idex_bubble`=1 and `ifid_clear`=0.
- R8: With no data stall and no branch in decode or execute, all five outputs are 0.
- R9: `ifid_hold` and `ifid_clear` are never both 1, and `pc_redirect` is 1 only while a branch is in execute.
- R10: A data stall together with a branch in execute gives `idex_bubble`=1, `ifid_clear`=1 and `ifid_hold`=0, with `pc_hold` and `pc_redirect` set as in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks only |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| dec_src | input | NUM_SRC*REG_W | Source register numbers of the decode instruction |
| prod_dst | input | NUM_PROD*REG_W | Destination numbers of the producers: execute, memory, write-back |
| prod_wr | input | NUM_PROD | Write flags of the producers, same order |
| dec_branch | input | 1 | Decode holds a branch |
| ex_branch | input | 1 | Execute holds a branch whose condition is resolved this cycle |
| ex_taken | input | 1 | Resolved outcome of the execute branch |
| pc_hold | output | 1 | Keep the fetch address unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_clear | output | 1 | Load a bubble into the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| pc_redirect | output | 1 | Load the branch target into the fetch address |

## Verification
The bench builds the block with its defaults: five-bit register numbers, two decode sources and three producers, which is the full shape of the pipeline. Random register numbers are drawn from only four values, so matches between sources and destinations, zero-register sources and cleared write flags all occur often. Every producer position and every pairing of data stall with decode or execute branches is reached many times. A directed walk moves a load through execute, memory and write-back to count the three bubbles one by one.

// File: rtl/hsc_pkg.sv
// Shared definitions for the hazard stall controller.
// Assumes producers are listed youngest first: execute, memory, write-back.
package hsc_pkg;
    typedef enum int unsigned {
        STG_EX  = 0,
        STG_MEM = 1,
        STG_WB  = 2
    } prod_stage_e;

    localparam int unsigned ZERO_REG = 0;
endpackage

// File: rtl/hsc_dep_match.sv
// One source-versus-producer comparator.
// Raises hit when the source names a real register that the producer writes.
// Assumes register zero is hard-wired and never written.
module hsc_dep_match #(
    parameter int unsigned REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wr,
    output logic             hit
);
    import hsc_pkg::*;

    localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

    logic src_live;

    // A source counts only when it is not the zero register.
    always_comb src_live = (src != ZR);

    // Dependency exists when a live source equals a written destination.
    always_comb hit = src_live && wr && (src == dst);

    assert_no_zero_dep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ZR || !wr) |-> !hit);
endmodule

// File: rtl/hsc_data_hazard.sv
// Data-hazard detector for a pipeline without forwarding.
// Compares every decode source against every in-flight producer and
// reports a single stall request. Assumes the register file is read in
// decode only after write-back has completed, so write-back is a producer too.
module hsc_data_hazard #(
    parameter int unsigned REG_W    = 5,
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned NUM_PROD = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC*REG_W-1:0]  dec_src,
    input  logic [NUM_PROD*REG_W-1:0] prod_dst,
    input  logic [NUM_PROD-1:0]       prod_wr,
    output logic                      data_stall
);
    localparam int unsigned NUM_PAIRS = NUM_SRC * NUM_PROD;

    logic [NUM_PAIRS-1:0] pair_hit;

    // One comparator for every source/producer pair.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
            hsc_dep_match #(.REG_W(REG_W)) i_match (
                .clk (clk),
                .rst_n (rst_n),
                .src (dec_src[s*REG_W +: REG_W]),
                .dst (prod_dst[p*REG_W +: REG_W]),
                .wr  (prod_wr[p]),
                .hit (pair_hit[s*NUM_PROD + p])
            );
        end
    end

    // Any matching pair stalls decode.
    always_comb data_stall = |pair_hit;

    assert_idle_producers_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_wr == '0) |-> !data_stall);
endmodule

// File: rtl/hsc_branch_guard.sv
// Combines the data stall with branch state into pipeline control.
// Assumes a branch resolves in execute for one cycle and that the
// datapath loads the target when pc_redirect is set and pc_hold is clear.
module hsc_branch_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic data_stall,
    input  logic dec_branch,
    input  logic ex_branch,
    input  logic ex_taken,
    output logic pc_hold,
    output logic ifid_hold,
    output logic ifid_clear,
    output logic idex_bubble,
    output logic pc_redirect
);
    // Jump to the target only on a resolved taken branch.
    always_comb pc_redirect = ex_branch && ex_taken;

    // Drop the fetched instruction behind a branch that is leaving decode or resolving.
    always_comb ifid_clear = ex_branch || (dec_branch && !data_stall);

    // Keep the decode instruction while it waits for its operands.
    always_comb ifid_hold = data_stall && !ex_branch;

    // Feed execute a bubble while decode is waiting.
    always_comb idex_bubble = data_stall;

    // Freeze fetch unless a taken branch redirects it.
    always_comb begin
        if (ex_branch) pc_hold = !ex_taken;
        else           pc_hold = data_stall || dec_branch;
    end

    assert_hold_clear_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifid_hold && ifid_clear));
    assert_redirect_needs_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> ex_branch);
    assert_dec_branch_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_branch && !data_stall && !ex_branch) |-> (pc_hold && ifid_clear && !idex_bubble));
    assert_not_taken_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_branch && !ex_taken) |-> (pc_hold && ifid_clear && !pc_redirect));
endmodule

// File: rtl/hazard_stall_ctrl.sv
// Top of the hazard stall controller for a five-stage in-order pipeline
// without forwarding. Resolves data and control hazards only by holding
// fetch and decode and inserting bubbles into execute.
// Assumes a bubble has all-zero sources and all write flags low.
module hazard_stall_ctrl #(
    parameter int unsigned REG_W    = 5,
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned NUM_PROD = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC*REG_W-1:0]  dec_src,
    input  logic [NUM_PROD*REG_W-1:0] prod_dst,
    input  logic [NUM_PROD-1:0]       prod_wr,
    input  logic                      dec_branch,
    input  logic                      ex_branch,
    input  logic                      ex_taken,
    output logic                      pc_hold,
    output logic                      ifid_hold,
    output logic                      ifid_clear,
    output logic                      idex_bubble,
    output logic                      pc_redirect
);
    logic data_stall;

    hsc_data_hazard #(
        .REG_W    (REG_W),
        .NUM_SRC  (NUM_SRC),
        .NUM_PROD (NUM_PROD)
    ) i_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_src    (dec_src),
        .prod_dst   (prod_dst),
        .prod_wr    (prod_wr),
        .data_stall (data_stall)
    );

    hsc_branch_guard i_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_stall  (data_stall),
        .dec_branch  (dec_branch),
        .ex_branch   (ex_branch),
        .ex_taken    (ex_taken),
        .pc_hold     (pc_hold),
        .ifid_hold   (ifid_hold),
        .ifid_clear  (ifid_clear),
        .idex_bubble (idex_bubble),
        .pc_redirect (pc_redirect)
    );

    assert_stall_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_bubble && !ex_branch) |-> (pc_hold && ifid_hold && !ifid_clear));
    assert_both_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_bubble && dec_branch && !ex_branch) |-> (pc_hold && ifid_hold && !ifid_clear));
    assert_ex_branch_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_bubble && ex_branch) |-> (ifid_clear && !ifid_hold));
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idex_bubble && !dec_branch && !ex_branch) |-> !(pc_hold || ifid_hold || ifid_clear || pc_redirect));
endmodule

// File: tb/test_hazard_stall_ctrl.sv
module test_hazard_stall_ctrl;
    localparam int REG_W = 5;
    localparam int NSRC  = 2;
    localparam int NPROD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC*REG_W-1:0]  dec_src = '0;
    logic [NPROD*REG_W-1:0] prod_dst = '0;
    logic [NPROD-1:0]       prod_wr = '0;
    logic dec_branch = 1'b0, ex_branch = 1'b0, ex_taken = 1'b0;
    logic pc_hold, ifid_hold, ifid_clear, idex_bubble, pc_redirect;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hazard_stall_ctrl #(.REG_W(REG_W), .NUM_SRC(NSRC), .NUM_PROD(NPROD)) i_hazard_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_src(dec_src), .prod_dst(prod_dst), .prod_wr(prod_wr),
        .dec_branch(dec_branch), .ex_branch(ex_branch), .ex_taken(ex_taken),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ifid_clear(ifid_clear),
        .idex_bubble(idex_bubble), .pc_redirect(pc_redirect)
    );

    // Data stall computed from R1/R2.
    function automatic bit exp_stall(input logic [NSRC*REG_W-1:0] s,
                                     input logic [NPROD*REG_W-1:0] d,
                                     input logic [NPROD-1:0] w);
        bit st = 0;
        for (int i = 0; i < NSRC; i++)
            for (int p = 0; p < NPROD; p++)
                if (s[i*REG_W +: REG_W] != 0 && w[p] && s[i*REG_W +: REG_W] == d[p*REG_W +: REG_W])
                    st = 1;
        return st;
    endfunction

    // Expected {pc_hold, ifid_hold, ifid_clear, idex_bubble, pc_redirect} from R2,R4-R8,R10.
    function automatic logic [4:0] exp_out(input bit st, input bit db, input bit eb, input bit tk);
        if (eb)      return {~tk, 1'b0, 1'b1, st, tk};
        else if (st) return 5'b11010;
        else if (db) return 5'b10100;
        else         return 5'b00000;
    endfunction

    function automatic string tag_of(input bit st, input bit db, input bit eb, input bit tk);
        if (eb && st) return "R10";
        if (eb)       return tk ? "R5" : "R6";
        if (st && db) return "R7";
        if (st)       return "R2";
        if (db)       return "R4";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply_check(input string tag_over);
        bit st;
        string t;
        #2;
        st = exp_stall(dec_src, prod_dst, prod_wr);
        t = (tag_over != "") ? tag_over : tag_of(st, dec_branch, ex_branch, ex_taken);
        check(t, {pc_hold, ifid_hold, ifid_clear, idex_bubble, pc_redirect},
              exp_out(st, dec_branch, ex_branch, ex_taken));
        if (ifid_hold && ifid_clear) check("R9", 5'b1, 5'b0);
        if (pc_redirect && !ex_branch) check("R9", 5'b1, 5'b0);
    endtask

    task automatic drive(input logic [NSRC*REG_W-1:0] s, input logic [NPROD*REG_W-1:0] d,
                         input logic [NPROD-1:0] w, input bit db, input bit eb, input bit tk);
        @(negedge clk);
        dec_src = s; prod_dst = d; prod_wr = w;
        dec_branch = db; ex_branch = eb; ex_taken = tk;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset/idle state: all outputs low (R8).
        drive('0, '0, '0, 0, 0, 0); apply_check("R8");

        // R1: zero-register source against zero destination written.
        drive({5'd0, 5'd0}, {5'd0, 5'd0, 5'd0}, 3'b111, 0, 0, 0); apply_check("R1");
        // R1: matching source but write flag low.
        drive({5'd7, 5'd9}, {5'd9, 5'd7, 5'd9}, 3'b000, 0, 0, 0); apply_check("R1");
        // R2: match in each producer position (execute, memory, write-back).
        drive({5'd0, 5'd4}, {5'd0, 5'd0, 5'd4}, 3'b001, 0, 0, 0); apply_check("R2");
        drive({5'd4, 5'd0}, {5'd0, 5'd4, 5'd0}, 3'b010, 0, 0, 0); apply_check("R2");
        drive({5'd31, 5'd1}, {5'd31, 5'd0, 5'd0}, 3'b100, 0, 0, 0); apply_check("R2");
        // R4, R5, R6, R7, R10 directed.
        drive({5'd3, 5'd2}, {5'd8, 5'd8, 5'd8}, 3'b111, 1, 0, 0); apply_check("R4");
        drive('0, '0, '0, 0, 1, 1); apply_check("R5");
        drive('0, '0, '0, 0, 1, 0); apply_check("R6");
        drive({5'd0, 5'd6}, {5'd0, 5'd6, 5'd0}, 3'b010, 1, 0, 0); apply_check("R7");
        drive({5'd0, 5'd6}, {5'd6, 5'd0, 5'd0}, 3'b001, 0, 1, 1); apply_check("R10");
        drive({5'd0, 5'd6}, {5'd6, 5'd0, 5'd0}, 3'b001, 0, 1, 0); apply_check("R10");

        // R3: load writing r5 enters execute; consumer in decode reads r5.
        begin
            logic [NPROD*REG_W-1:0] d;
            logic [NPROD-1:0] w;
            int bubbles = 0;
            int release_cycle = -1;
            d = {5'd0, 5'd0, 5'd5};
            w = 3'b001;
            for (int c = 0; c < 5; c++) begin
                drive({5'd0, 5'd5}, d, w, 0, 0, 0);
                #2;
                if (idex_bubble) bubbles++;
                else if (release_cycle < 0) release_cycle = c;
                // Advance: bubble enters execute, older producers move on.
                d = {d[2*REG_W-1:0], 5'd0};
                w = {w[1:0], 1'b0};
                if (!idex_bubble) w = '0;
            end
            check("R3", 5'(bubbles), 5'd3);
            check("R3", 5'(release_cycle), 5'd3);
        end

        // Constrained random: register numbers 0..3, branches occasional.
        for (int n = 0; n < 400; n++) begin
            logic [NSRC*REG_W-1:0] s;
            logic [NPROD*REG_W-1:0] d;
            bit eb;
            for (int i = 0; i < NSRC; i++) s[i*REG_W +: REG_W] = 5'($urandom_range(0, 3));
            for (int p = 0; p < NPROD; p++) d[p*REG_W +: REG_W] = 5'($urandom_range(0, 3));
            eb = ($urandom_range(0, 3) == 0);
            drive(s, d, 3'($urandom_range(0, 7)), ($urandom_range(0, 2) == 0), eb,
                  1'($urandom_range(0, 1)));
            apply_check("");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule